// File: doc/BRIEF.md
# Host-bus stall bridge

This block lets a slow servicing agent answer accesses that an 8-bit host CPU makes to a 16-byte memory-mapped window. Whenever the host places an address inside the window with its memory-request strobe active, the bridge pulls the active-low wait line at once. It does not wait for the read or write strobe. This gives the host a stall early enough in the bus cycle to be honoured every time.

Once a read or write strobe shows up inside the stalled access, the bridge raises a request to the servicer. It records the access kind and the low address nibble. On a write it also records the data byte in a holding register, so the servicer never has to sample a bus that may already be floating. For a read, the bridge drives the byte the servicer supplies onto the host data bus. It does so only while the read strobe and the window match are both present.

The servicer ends an access with a one-cycle acknowledge pulse. One clock later the wait line releases and the request drops. A new stall cannot start until the host has let go of the memory-request, read and write strobes. A 16-bit store therefore shows up as two separate stalled byte writes, each with its own request and acknowledge. All bus inputs are assumed to be already synchronous to `clk`.

Top module: `hostbus_stall_bridge`

## Requirements
- R1: The window is addresses 0x37E0 to 0x37EF, and only while `bus_mreq_n` is low. Any other address, or any address while `bus_mreq_n` is high, leaves `bus_wait_n` high and `svc_req` low, even with a strobe active.
- R2: In the idle phase, `bus_wait_n` goes low in the same cycle as the window match appears, before any read or write strobe is active.
- R3: `svc_req` rises one clock after the first cycle of a stall in which `bus_rd_n` or `bus_wr_n` is low. `svc_is_wr` is 1 for a write and 0 for a read.
- R4: On a write request, `svc_wdata` holds the value of `bus_din` and `svc_ofs` holds `bus_addr[3:0]`, both as sampled in that first strobe cycle. Both stay unchanged until acknowledge, even if `bus_din` changes.
- R5: While `svc_req` is high and `svc_ack` is low, `bus_wait_n` stays low. In the cycle after a cycle with `svc_ack` high, `bus_wait_n` is high and `svc_req` is low.
- R6: A `svc_ack` pulse while no request is pending has no effect. In idle it raises no request and no stall. In a stall before any strobe it neither releases the wait nor raises a request.
- R7: `bus_doe` is 1 exactly when `bus_rd_n` is low and the window matches. `bus_dout` then equals `svc_rdata` in the same cycle; otherwise `bus_dout` is 0.
- R8: After a release, `bus_wait_n` stays high as long as any of `bus_mreq_n`, `bus_rd_n`, `bus_wr_n` is low. Once all three have been high for one clock, the next window match stalls again.
- R9: A 16-bit store of low byte to 0x37EE and high byte to 0x37EF produces two separate requests. The first carries offset 0xE with the low byte, and the second carries offset 0xF with the high byte.
- R10: Under synchronous reset with the bus idle, `bus_wait_n` is 1, `svc_req` is 0 and `bus_doe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; bus inputs are synchronous to it |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 16 | Host address bus |
| bus_mreq_n | input | 1 | Host memory-request strobe, active low |
| bus_rd_n | input | 1 | Host read strobe, active low |
| bus_wr_n | input | 1 | Host write strobe, active low |
| bus_din | input | 8 | Host data bus as seen by the bridge |
| bus_dout | output | 8 | Read byte for the host data bus |
| bus_doe | output | 1 | Drive enable for the host data bus pad; low means tri-stated |
| bus_wait_n | output | 1 | Wait line to the host, active low |
| svc_req | output | 1 | Access pending for the servicer |
| svc_is_wr | output | 1 | Pending access is a write (1) or a read (0) |
| svc_ofs | output | 4 | Captured low address nibble of the pending access |
| svc_wdata | output | 8 | Captured write byte |
| svc_rdata | input | 8 | Byte the servicer returns for reads |
| svc_ack | input | 1 | One-cycle completion pulse from the servicer |

## Verification
Single writes and reads are run with different acknowledge delays. These separate a stall that is armed from the address match from one that is armed later by the strobe. The bus data is changed after capture to show that the holding register, not the live bus, feeds the servicer. Addresses just outside the window, and accesses with the memory-request strobe high, show that the decode is exact. A back-to-back pair of stores to the top two offsets shows that each byte gets its own request and release. Stray acknowledges, and strobes held low after a release, show that neither can end a stall early or re-arm one.

// File: rtl/hsb_pkg.sv
// Package: shared types of the host-bus stall bridge.
// Assumes: nothing beyond IEEE 1800-2017.
package hsb_pkg;

    // Phases of one window access as seen by the stall controller.
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,   // no access in progress, stall may be armed
        PH_STALL = 2'd1,   // wait held low, request pending or about to be
        PH_DONE  = 2'd2    // released, waiting for the host strobes to clear
    } stall_ph_e;

endpackage

// File: rtl/hsb_window_decode.sv
// Module: hsb_window_decode
// Compares the upper address bits with the window base. The match is
// qualified by the memory-request strobe. It also splits off the offset
// inside the window.
// Assumes: WIN_BASE is aligned to 2**WIN_BITS.
module hsb_window_decode #(
    parameter int ADDR_W   = 16,
    parameter int WIN_BITS = 4,
    parameter logic [ADDR_W-1:0] WIN_BASE = 16'h37E0
) (
    input  logic [ADDR_W-1:0]   addr,
    input  logic                mreq_n,
    output logic                hit,
    output logic [WIN_BITS-1:0] ofs
);
    localparam int TAG_W = ADDR_W - WIN_BITS;
    localparam logic [TAG_W-1:0] BASE_TAG = WIN_BASE[ADDR_W-1:WIN_BITS];

    // Window match: tag equal and memory request active.
    always_comb begin
        hit = (addr[ADDR_W-1:WIN_BITS] == BASE_TAG) && !mreq_n;
        ofs = addr[WIN_BITS-1:0];
    end
endmodule

// File: rtl/hsb_stall_ctrl.sv
// Module: hsb_stall_ctrl
// Holds the wait flip-flop and the request flag. The stall is armed from
// the window match alone. The request is raised on the first strobe cycle
// and cleared by the servicer acknowledge. Re-arming waits until all host
// strobes are inactive.
// Assumes: the host does not drop the window address while wait is low.
module hsb_stall_ctrl
    import hsb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hit,
    input  logic mreq_n,
    input  logic rd_n,
    input  logic wr_n,
    input  logic ack,
    output logic wait_n,
    output logic req,
    output logic cap_en
);
    stall_ph_e ph_q;
    logic      req_q;
    logic      strobe;
    logic      quiet;

    // Strobe presence and bus-quiet detection.
    always_comb begin
        strobe = !rd_n || !wr_n;
        quiet  = mreq_n && rd_n && wr_n;
        cap_en = (ph_q == PH_STALL) && !req_q && strobe;
    end

    // Wait is pulled low at once on a match in idle, and held through the stall.
    always_comb begin
        wait_n = !((ph_q == PH_STALL) || ((ph_q == PH_IDLE) && hit));
        req    = req_q;
    end

    // Phase and request sequencing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q  <= PH_IDLE;
            req_q <= 1'b0;
        end else begin
            case (ph_q)
                PH_IDLE: begin
                    if (hit) ph_q <= PH_STALL;
                end
                PH_STALL: begin
                    if (cap_en) begin
                        req_q <= 1'b1;
                    end else if (req_q && ack) begin
                        req_q <= 1'b0;
                        ph_q  <= PH_DONE;
                    end
                end
                PH_DONE: begin
                    if (quiet) ph_q <= PH_IDLE;
                end
                default: ph_q <= PH_IDLE;
            endcase
        end
    end

    // A pending request keeps the host stalled.
    AST_REQ_HOLDS_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !ack) |=> !wait_n);                                   // R5
    // Acknowledge of a pending request releases wait and request together.
    AST_ACK_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        (req && ack) |=> (wait_n && !req));                           // R5
    // A request only appears while the host is stalled.
    AST_REQ_IN_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req) |-> !wait_n);                                      // R3
    // No re-arm while any host strobe is still active after a release.
    AST_NO_EARLY_REARM: assert property (@(posedge clk) disable iff (!rst_n)
        ((ph_q == PH_DONE) && !quiet) |=> wait_n);                    // R8
endmodule

// File: rtl/hsb_write_capture.sv
// Module: hsb_write_capture
// Holding register for the access handed to the servicer: kind, window
// offset and, for writes, the data byte. It loads only on the capture
// enable from the stall controller and holds until the next capture.
// Assumes: cap_en is a single-cycle pulse per access.
module hsb_write_capture #(
    parameter int DATA_W = 8,
    parameter int OFS_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_en,
    input  logic              wr_n,
    input  logic [DATA_W-1:0] din,
    input  logic [OFS_W-1:0]  ofs_in,
    output logic              is_wr,
    output logic [OFS_W-1:0]  ofs,
    output logic [DATA_W-1:0] wdata
);
    // Capture kind, offset and write byte on the first strobe cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            is_wr <= 1'b0;
            ofs   <= '0;
            wdata <= '0;
        end else if (cap_en) begin
            is_wr <= !wr_n;
            ofs   <= ofs_in;
            if (!wr_n) wdata <= din;
        end
    end
endmodule

// File: rtl/hsb_read_drive.sv
// Module: hsb_read_drive
// Puts the servicer's byte on the host data bus during a read inside the
// window. Outside that, the output bits are zero and the enable is low, so
// the pad is tri-stated.
// Assumes: the pad combines dout and doe outside this block.
module hsb_read_drive #(
    parameter int DATA_W = 8
) (
    input  logic              hit,
    input  logic              rd_n,
    input  logic [DATA_W-1:0] rdata,
    output logic [DATA_W-1:0] dout,
    output logic              doe
);
    // Drive enable: read strobe within the window.
    always_comb doe = hit && !rd_n;

    // Gate each data bit with the drive enable.
    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
        assign dout[i] = doe & rdata[i];
    end
endmodule

// File: rtl/hostbus_stall_bridge.sv
// Module: hostbus_stall_bridge
// Top of the host-bus stall bridge: window decode, stall controller,
// holding register and read driver.
// Assumes: all bus inputs are synchronous to clk; svc_ack is a one-cycle
// pulse given only for a pending request.
module hostbus_stall_bridge #(
    parameter int ADDR_W   = 16,
    parameter int DATA_W   = 8,
    parameter int WIN_BITS = 4,
    parameter logic [ADDR_W-1:0] WIN_BASE = 16'h37E0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_mreq_n,
    input  logic                bus_rd_n,
    input  logic                bus_wr_n,
    input  logic [DATA_W-1:0]   bus_din,
    output logic [DATA_W-1:0]   bus_dout,
    output logic                bus_doe,
    output logic                bus_wait_n,
    output logic                svc_req,
    output logic                svc_is_wr,
    output logic [WIN_BITS-1:0] svc_ofs,
    output logic [DATA_W-1:0]   svc_wdata,
    input  logic [DATA_W-1:0]   svc_rdata,
    input  logic                svc_ack
);
    logic                win_hit;
    logic [WIN_BITS-1:0] win_ofs;
    logic                cap_en;

    hsb_window_decode #(
        .ADDR_W   (ADDR_W),
        .WIN_BITS (WIN_BITS),
        .WIN_BASE (WIN_BASE)
    ) u_decode (
        .addr   (bus_addr),
        .mreq_n (bus_mreq_n),
        .hit    (win_hit),
        .ofs    (win_ofs)
    );

    hsb_stall_ctrl u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .hit    (win_hit),
        .mreq_n (bus_mreq_n),
        .rd_n   (bus_rd_n),
        .wr_n   (bus_wr_n),
        .ack    (svc_ack),
        .wait_n (bus_wait_n),
        .req    (svc_req),
        .cap_en (cap_en)
    );

    hsb_write_capture #(
        .DATA_W (DATA_W),
        .OFS_W  (WIN_BITS)
    ) u_capture (
        .clk    (clk),
        .rst_n  (rst_n),
        .cap_en (cap_en),
        .wr_n   (bus_wr_n),
        .din    (bus_din),
        .ofs_in (win_ofs),
        .is_wr  (svc_is_wr),
        .ofs    (svc_ofs),
        .wdata  (svc_wdata)
    );

    hsb_read_drive #(
        .DATA_W (DATA_W)
    ) u_read (
        .hit   (win_hit),
        .rd_n  (bus_rd_n),
        .rdata (svc_rdata),
        .dout  (bus_dout),
        .doe   (bus_doe)
    );

    // Wait falls only when the decoder reports a window match.
    AST_WAIT_FROM_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_wait_n) |-> win_hit);                               // R2
    // The captured access is frozen while the request is pending.
    AST_LATCH_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (svc_req && $past(svc_req)) |-> ($stable(svc_wdata) && $stable(svc_ofs)));  // R4
    // The bus is never driven during a host write.
    AST_NO_DRIVE_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        bus_doe |-> bus_wr_n);                                        // R7
endmodule

// File: tb/hostbus_stall_bridge_bench.sv
// Bench: behavioural reference compared every cycle, plus directed checks.
module hostbus_stall_bridge_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] bus_addr = 16'h0000;
    logic        bus_mreq_n = 1'b1;
    logic        bus_rd_n = 1'b1;
    logic        bus_wr_n = 1'b1;
    logic [7:0]  bus_din = 8'h00;
    logic [7:0]  bus_dout;
    logic        bus_doe;
    logic        bus_wait_n;
    logic        svc_req;
    logic        svc_is_wr;
    logic [3:0]  svc_ofs;
    logic [7:0]  svc_wdata;
    logic [7:0]  svc_rdata = 8'h00;
    logic        svc_ack = 1'b0;

    int checks = 0;
    int errs = 0;
    int req_rises = 0;
    logic prev_req = 1'b0;

    always #4 clk = ~clk;

    hostbus_stall_bridge u_hostbus_stall_bridge (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_mreq_n(bus_mreq_n),
        .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n), .bus_din(bus_din),
        .bus_dout(bus_dout), .bus_doe(bus_doe), .bus_wait_n(bus_wait_n),
        .svc_req(svc_req), .svc_is_wr(svc_is_wr), .svc_ofs(svc_ofs),
        .svc_wdata(svc_wdata), .svc_rdata(svc_rdata), .svc_ack(svc_ack)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Reference model: phase 0 idle, 1 stalled, 2 released.
    int       m_ph = 0;
    bit       m_req = 0;
    bit       m_wr = 0;
    bit [3:0] m_ofs = 0;
    bit [7:0] m_wd = 0;

    function automatic bit m_hit();
        return !bus_mreq_n && (bus_addr >= 16'h37E0) && (bus_addr <= 16'h37EF);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ph = 0; m_req = 0; m_wr = 0; m_ofs = 0; m_wd = 0;
        end else if (m_ph == 0) begin
            if (m_hit()) m_ph = 1;
        end else if (m_ph == 1) begin
            if (!m_req && (!bus_rd_n || !bus_wr_n)) begin
                m_req = 1; m_wr = !bus_wr_n; m_ofs = bus_addr[3:0];
                if (!bus_wr_n) m_wd = bus_din;
            end else if (m_req && svc_ack) begin
                m_req = 0; m_ph = 2;
            end
        end else begin
            if (bus_mreq_n && bus_rd_n && bus_wr_n) m_ph = 0;
        end
    end

    // Every-cycle comparison against the model, away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            automatic bit e_wait = !(m_ph == 1 || (m_ph == 0 && m_hit()));
            automatic bit e_doe = m_hit() && !bus_rd_n;
            chk(bus_wait_n == e_wait, "R2 wait", bus_wait_n, e_wait);
            chk(svc_req == m_req, "R3 req", svc_req, m_req);
            chk(svc_is_wr == m_wr, "R3 kind", svc_is_wr, m_wr);
            chk(svc_ofs == m_ofs, "R4 ofs", svc_ofs, m_ofs);
            chk(svc_wdata == m_wd, "R4 wdata", svc_wdata, m_wd);
            chk(bus_doe == e_doe, "R7 doe", bus_doe, e_doe);
            chk(bus_dout == (e_doe ? svc_rdata : 8'h00), "R7 dout", bus_dout,
                e_doe ? svc_rdata : 8'h00);
            if (svc_req && !prev_req) req_rises++;
            prev_req = svc_req;
        end
    end

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic host_write(input logic [15:0] a, input logic [7:0] d, input int lag, input int hold);
        step(); bus_mreq_n = 1'b0; bus_addr = a; bus_din = d;
        @(negedge clk); chk(!bus_wait_n, "R2 early stall", bus_wait_n, 0);
        step(); bus_wr_n = 1'b0;
        @(negedge clk); chk(!svc_req, "R3 no req yet", svc_req, 0);
        step(); bus_din = 8'hFF;
        @(negedge clk);
        chk(svc_req && svc_is_wr, "R3 write req", {svc_req, svc_is_wr}, 3);
        chk(svc_wdata == d, "R4 data held", svc_wdata, d);
        chk(svc_ofs == a[3:0], "R4 offset", svc_ofs, a[3:0]);
        for (int i = 0; i < lag; i++) begin
            step();
            @(negedge clk); chk(!bus_wait_n, "R5 held", bus_wait_n, 0);
        end
        step(); svc_ack = 1'b1;
        @(negedge clk); chk(!bus_wait_n, "R5 ack cycle", bus_wait_n, 0);
        step(); svc_ack = 1'b0;
        @(negedge clk); chk(bus_wait_n && !svc_req, "R5 release", {bus_wait_n, svc_req}, 2);
        for (int i = 0; i < hold; i++) begin
            step();
            @(negedge clk); chk(bus_wait_n, "R8 no rearm", bus_wait_n, 1);
        end
        step(); bus_wr_n = 1'b1; bus_mreq_n = 1'b1; bus_addr = 16'h0000;
    endtask

    task automatic host_read(input logic [15:0] a, input logic [7:0] d, input int lag);
        step(); bus_mreq_n = 1'b0; bus_addr = a;
        @(negedge clk); chk(!bus_wait_n && !bus_doe, "R7 no drive before strobe", bus_doe, 0);
        step(); bus_rd_n = 1'b0; svc_rdata = d;
        @(negedge clk); chk(bus_doe && bus_dout == d, "R7 drive", bus_dout, d);
        step();
        @(negedge clk); chk(svc_req && !svc_is_wr, "R3 read req", {svc_req, svc_is_wr}, 2);
        for (int i = 0; i < lag; i++) step();
        step(); svc_ack = 1'b1;
        step(); svc_ack = 1'b0;
        @(negedge clk); chk(bus_wait_n && !svc_req, "R5 read release", {bus_wait_n, svc_req}, 2);
        step(); bus_rd_n = 1'b1; bus_mreq_n = 1'b1; bus_addr = 16'h0000;
        @(negedge clk); chk(!bus_doe && bus_dout == 8'h00, "R7 tri-state", bus_doe, 0);
    endtask

    task automatic outside(input logic [15:0] a, input logic mreq);
        step(); bus_mreq_n = mreq; bus_addr = a; bus_din = 8'h5A;
        step(); bus_wr_n = 1'b0;
        @(negedge clk); chk(bus_wait_n && !svc_req, "R1 outside", {bus_wait_n, svc_req}, 2);
        step();
        @(negedge clk); chk(bus_wait_n && !svc_req, "R1 outside", {bus_wait_n, svc_req}, 2);
        step(); bus_wr_n = 1'b1; bus_mreq_n = 1'b1; bus_addr = 16'h0000;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(bus_wait_n && !svc_req && !bus_doe, "R10 reset",
            {bus_wait_n, svc_req, bus_doe}, 4);
        step(); rst_n = 1'b1;

        outside(16'h37F0, 1'b0);
        outside(16'h37DF, 1'b0);
        outside(16'h37E5, 1'b1);

        host_write(16'h37E1, 8'h01, 0, 0);
        host_write(16'h37EC, 8'hFE, 4, 0);
        host_read(16'h37EC, 8'h24, 2);
        host_read(16'h37EF, 8'h13, 0);

        // 16-bit store to the top two offsets.
        req_rises = 0;
        host_write(16'h37EE, 8'h05, 1, 0);
        host_write(16'h37EF, 8'h00, 1, 0);
        step();
        @(negedge clk); chk(req_rises == 2, "R9 two requests", req_rises, 2);

        // Strobes kept low after release must not re-arm.
        host_write(16'h37E3, 8'hA7, 0, 3);
        host_write(16'h37E3, 8'h3C, 0, 0);

        // Stray acknowledge in idle.
        step(); svc_ack = 1'b1;
        step(); svc_ack = 1'b0;
        @(negedge clk); chk(bus_wait_n && !svc_req, "R6 idle ack", {bus_wait_n, svc_req}, 2);
        // Stray acknowledge during a stall before any strobe.
        step(); bus_mreq_n = 1'b0; bus_addr = 16'h37E8;
        step(); svc_ack = 1'b1;
        step(); svc_ack = 1'b0;
        @(negedge clk); chk(!bus_wait_n && !svc_req, "R6 stall ack", {bus_wait_n, svc_req}, 0);
        step(); bus_wr_n = 1'b0; bus_din = 8'h77;
        step();
        @(negedge clk); chk(svc_req && svc_wdata == 8'h77, "R4 late strobe", svc_wdata, 8'h77);
        step(); svc_ack = 1'b1;
        step(); svc_ack = 1'b0; bus_wr_n = 1'b1; bus_mreq_n = 1'b1;
        @(negedge clk); chk(bus_wait_n, "R5 late release", bus_wait_n, 1);
        repeat (3) step();

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errs++;
        checks++;
        $display("FAIL watchdog: actual=expired expected=done");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule